// File: doc/BRIEF.md
# Asynchronous Static RAM Interface Controller

This block lets a synchronous internal bus read and write a byte-wide asynchronous static RAM of 128K locations that has one active-low chip enable. The internal side raises a one-cycle request strobe with a write flag, a 17-bit address and a write byte. The controller then runs one complete memory cycle on the RAM pins and answers with a one-cycle completion pulse. For a read, the fetched byte is presented with that pulse.

Every interval on the memory pins is counted in clock cycles. Each count comes from a clock-period parameter and from the RAM's minimum timing limits: the read cycle and access times, the write pulse width, chip-enable and address time before the end of a write, data setup before the write ends, and the bus release time after output enable is removed. The shared data bus is modelled as separate out, in and drive-enable signals. The controller drives the bus only in its write phases. It holds the chip enable high whenever no transaction is under way, which keeps the RAM in standby.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after reset, mem_ce_n, mem_oe_n and mem_we_n are high, and mem_dout_en and rsp_done are low.
- R2: A read holds mem_ce_n and mem_oe_n low and mem_we_n high for exactly 6 consecutive cycles at the default 10 ns clock. rsp_rdata then equals the byte the RAM presented at mem_din in the last of those cycles.
- R3: A write holds mem_we_n low for exactly 4 consecutive cycles at the default 10 ns clock. In each of those cycles mem_ce_n is low, mem_oe_n is high and mem_dout_en is high. The byte stored when mem_we_n rises is the request's write data.
- R4: rsp_done is high for exactly one cycle per accepted request. When no bus turnaround stall is needed, it rises on the sixth clock edge after the edge that accepted the request, for reads and writes alike.
- R5: A request raised while a transaction is under way is ignored. It produces no extra rsp_done pulse and no memory cycle, and the location it names keeps its previous contents.
- R6: mem_addr and mem_dout stay unchanged in every cycle where mem_we_n is low and in the first cycle after mem_we_n rises, whatever the request inputs do.
- R7: mem_dout_en is never high while mem_oe_n is low. mem_dout_en rises no earlier than 2 cycles (the release time in cycles) after mem_oe_n last rose.
- R8: mem_ce_n is high in the cycle in which rsp_done is high and in every cycle with no transaction in progress.
- R9: The lowest address 0x00000 and the highest address 0x1FFFF reach mem_addr intact, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request strobe, sampled only when idle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Request address |
| req_wdata | input | 8 | Write byte |
| rsp_rdata | output | 8 | Byte returned by the last read |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dout | output | 8 | Byte driven toward the RAM data pins |
| mem_din | input | 8 | Byte received from the RAM data pins |
| mem_dout_en | output | 1 | Drive enable for mem_dout onto the shared bus |

## Verification
A phase counter loaded with the wrong length shows up at once as a write-enable or output-enable pulse of the wrong width. It also moves the completion pulse off its sixth-edge position, so the error is visible within the first transaction. A stuck or lost state shows as a missing completion within a few tens of cycles, or as the chip enable staying low between transactions. A release-counter fault shows as the drive enable rising while, or too soon after, output enable is low, on the first write that follows a read. A capture or hold fault shows as a wrong byte read back on the next read of that location.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared phase type and cycle-count arithmetic for the SRAM controller.
// Assumes timing values are positive integers in nanoseconds.
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_READ   = 3'd1,
        PH_WSETUP = 3'd2,
        PH_WPULSE = 3'd3,
        PH_WREC   = 3'd4
    } phase_t;

    // Whole cycles covering a time in ns, never less than one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
// Module: phase-length down counter.
// Loaded with (cycles - 1) on the edge that enters a phase; done_o is high
// in the final cycle of that phase. Assumes load values fit in W bits.
module sram_ctrl_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         done_o
);

    logic [W-1:0] cnt_q;

    // Load on phase entry, otherwise count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_turn.sv
// Module: bus release tracker.
// Loaded when output enable is removed after a read; free_o tells the
// sequencer that driving the bus on the next edge respects the RAM's
// release time of HZ_CYC cycles. Free out of reset.
module sram_ctrl_turn #(
    parameter int HZ_CYC = 2,
    parameter int W      = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic release_i,
    output logic free_o
);

    logic [W-1:0] cnt_q;

    // Start the release window on a read end, then count it out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (release_i)
            cnt_q <= W'(HZ_CYC);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - W'(1);
    end

    assign free_o = (cnt_q <= W'(1));

    // R7
    release_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |=> !free_o || (HZ_CYC <= 1));

endmodule

// File: rtl/sram_ctrl_fsm.sv
// Module: transaction sequencer.
// Accepts a request only when idle, steps through read or write phases and
// drives the RAM control pins and completion pulse from registers, so the
// pins are glitch-free. Phase lengths come from the timer; a write's drive
// phase waits for the release tracker.
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int RD_CYC = 6,
    parameter int WP_CYC = 4,
    parameter int CW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          req_wr_i,
    input  logic          tmr_done_i,
    input  logic          bus_free_i,
    output logic          tmr_load_o,
    output logic [CW-1:0] tmr_val_o,
    output logic          accept_o,
    output logic          capture_o,
    output logic          release_o,
    output logic          ce_n_o,
    output logic          oe_n_o,
    output logic          we_n_o,
    output logic          dout_en_o,
    output logic          done_o
);

    phase_t ph_q, ph_d;

    // Next phase and one-cycle strobes for timer, capture and release.
    always_comb begin
        ph_d       = ph_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        accept_o   = 1'b0;
        capture_o  = 1'b0;
        release_o  = 1'b0;
        unique case (ph_q)
            PH_IDLE: begin
                if (req_i) begin
                    accept_o = 1'b1;
                    if (req_wr_i) begin
                        ph_d = PH_WSETUP;
                    end else begin
                        ph_d       = PH_READ;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = CW'(RD_CYC - 1);
                    end
                end
            end
            PH_READ: begin
                if (tmr_done_i) begin
                    ph_d      = PH_IDLE;
                    capture_o = 1'b1;
                    release_o = 1'b1;
                end
            end
            PH_WSETUP: begin
                if (bus_free_i) begin
                    ph_d       = PH_WPULSE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = CW'(WP_CYC - 1);
                end
            end
            PH_WPULSE: begin
                if (tmr_done_i)
                    ph_d = PH_WREC;
            end
            PH_WREC: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // Phase register and registered pin controls derived from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q      <= PH_IDLE;
            ce_n_o    <= 1'b1;
            oe_n_o    <= 1'b1;
            we_n_o    <= 1'b1;
            dout_en_o <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            ph_q      <= ph_d;
            ce_n_o    <= (ph_d == PH_IDLE);
            oe_n_o    <= (ph_d != PH_READ);
            we_n_o    <= (ph_d != PH_WPULSE);
            dout_en_o <= (ph_d == PH_WPULSE) || (ph_d == PH_WREC);
            done_o    <= capture_o || (ph_q == PH_WREC);
        end
    end

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3
    we_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> (!ce_n_o && oe_n_o && dout_en_o));

    // R5
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q != PH_IDLE) |-> !accept_o);

endmodule

// File: rtl/sram_ctrl.sv
// Module: top of the asynchronous SRAM controller.
// Registers address and write byte on acceptance and holds them until the
// next acceptance, captures read data at the end of the read phase, and
// derives all phase lengths from CLK_NS and the RAM's minimum timings.
// Assumes the RAM's data-out delay fits inside the read phase.
module sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int CLK_NS   = 10,
    parameter int T_RC_NS  = 55,
    parameter int T_AA_NS  = 55,
    parameter int T_OE_NS  = 30,
    parameter int T_WP_NS  = 40,
    parameter int T_CW_NS  = 50,
    parameter int T_AW_NS  = 50,
    parameter int T_DW_NS  = 25,
    parameter int T_HZ_NS  = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dout,
    input  logic [DW-1:0] mem_din,
    output logic          mem_dout_en
);

    // Read phase covers cycle time, address access and output-enable access.
    localparam int RD_CYC = imax(ns_to_cyc(T_RC_NS, CLK_NS),
                            imax(ns_to_cyc(T_AA_NS, CLK_NS),
                                 ns_to_cyc(T_OE_NS, CLK_NS)));
    // WE pulse covers pulse width and data setup; CE/address time also count
    // the setup cycle; the whole write (setup + pulse + recovery) covers T_RC.
    localparam int WP_CYC = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS),
                                      ns_to_cyc(T_DW_NS, CLK_NS)),
                            imax(imax(ns_to_cyc(T_CW_NS, CLK_NS) - 1,
                                      ns_to_cyc(T_AW_NS, CLK_NS) - 1),
                                 ns_to_cyc(T_RC_NS, CLK_NS) - 2));
    localparam int HZ_CYC = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int CW     = $clog2(imax(RD_CYC, WP_CYC) + 1);
    localparam int HW     = $clog2(HZ_CYC + 1) + 1;

    logic          tmr_load, tmr_done, accept, capture, rel, bus_free;
    logic [CW-1:0] tmr_val;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdat_q, rdat_q;

    sram_ctrl_timer #(.W(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .done_o     (tmr_done)
    );

    sram_ctrl_turn #(.HZ_CYC(HZ_CYC), .W(HW)) u_turn (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_i (rel),
        .free_o    (bus_free)
    );

    sram_ctrl_fsm #(.RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .CW(CW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (req),
        .req_wr_i   (req_wr),
        .tmr_done_i (tmr_done),
        .bus_free_i (bus_free),
        .tmr_load_o (tmr_load),
        .tmr_val_o  (tmr_val),
        .accept_o   (accept),
        .capture_o  (capture),
        .release_o  (rel),
        .ce_n_o     (mem_ce_n),
        .oe_n_o     (mem_oe_n),
        .we_n_o     (mem_we_n),
        .dout_en_o  (mem_dout_en),
        .done_o     (rsp_done)
    );

    // Latch address and write byte only when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            wdat_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            wdat_q <= req_wdata;
        end
    end

    // Capture the RAM byte in the last read cycle, before OE is raised.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdat_q <= '0;
        else if (capture)
            rdat_q <= mem_din;
    end

    assign mem_addr  = addr_q;
    assign mem_dout  = wdat_q;
    assign rsp_rdata = rdat_q;

    // Checker state: cycles since OE was last high-going, saturating.
    logic [HW-1:0] since_oe_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_oe_q <= HW'(HZ_CYC);
        else if (!mem_oe_n)
            since_oe_q <= '0;
        else if (since_oe_q < HW'(HZ_CYC))
            since_oe_q <= since_oe_q + HW'(1);
    end

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dout_en |-> mem_oe_n);

    // R7
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dout_en) |-> (since_oe_q >= HW'(HZ_CYC)));

    // R6
    hold_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |=> ($stable(mem_addr) && $stable(mem_dout)));

    // R2
    read_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n));

    // R8
    standby_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> mem_ce_n);

endmodule

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_wr = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dout_en;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = 8'hEE;

    int n_chk = 0;
    int n_bad = 0;
    int n_done = 0;
    bit mon_on = 1'b0;

    always #5 clk = ~clk;

    sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .rsp_done(rsp_done), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dout(mem_dout),
        .mem_din(mem_din), .mem_dout_en(mem_dout_en)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    // RAM model and shadow of expected contents (kept separately).
    logic [7:0] dev [int];
    logic [7:0] shadow [int];

    function automatic logic [7:0] peek(input int a);
        return dev.exists(a) ? dev[a] : 8'h00;
    endfunction
    function automatic logic [7:0] expect_at(input int a);
        return shadow.exists(a) ? shadow[a] : 8'h00;
    endfunction

    // RAM behaviour and pin-level timing monitor, at the falling edge.
    logic        p_we = 1'b1, p_oe = 1'b1, p_den = 1'b0;
    logic [16:0] p_addr = '0;
    logic [7:0]  p_dout = '0;
    int wlen = 0, rlen = 0, gap = 100;
    always @(negedge clk) begin
        if (p_we == 1'b0 && mem_we_n == 1'b1 && !mem_ce_n)
            dev[int'(mem_addr)] = mem_dout;
        mem_din <= (!mem_ce_n && !mem_oe_n && mem_we_n) ? peek(int'(mem_addr)) : 8'hEE;
        if (rsp_done) n_done++;
        if (mon_on) begin
            if (!mem_we_n) begin
                wlen++;
                chk(!mem_ce_n && mem_oe_n && mem_dout_en, "R3 ctrl during WE low", {mem_ce_n, mem_oe_n, mem_dout_en}, 3'b011);
            end else if (wlen > 0) begin
                chk(wlen == 4, "R3 WE low width", wlen, 4);
                wlen = 0;
            end
            if (!mem_oe_n) begin
                rlen++;
                chk(!mem_ce_n && mem_we_n, "R2 ctrl during OE low", {mem_ce_n, mem_we_n}, 2'b01);
            end else if (rlen > 0) begin
                chk(rlen == 6, "R2 OE low width", rlen, 6);
                rlen = 0;
            end
            if (!p_we)
                chk(mem_addr == p_addr && mem_dout == p_dout, "R6 hold", int'(mem_addr), int'(p_addr));
            if (mem_dout_en && !mem_oe_n)
                chk(1'b0, "R7 contention", 1, 0);
            if (mem_dout_en && !p_den)
                chk(gap >= 2, "R7 turnaround", gap, 2);
            if (rsp_done)
                chk(mem_ce_n, "R8 CE high at done", int'(mem_ce_n), 1);
        end
        if (mem_oe_n && !p_oe) gap = 1;
        else if (gap < 100) gap++;
        p_we = mem_we_n; p_oe = mem_oe_n; p_den = mem_dout_en;
        p_addr = mem_addr; p_dout = mem_dout;
    end

    // One request; returns falling edges from strobe to done (7 expected).
    task automatic do_req(input bit wr, input logic [16:0] a, input logic [7:0] d, output int lat);
        req = 1'b1; req_wr = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req = 1'b0; req_addr = ~a; req_wdata = ~d;
        lat = 1;
        while (!rsp_done && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        if (wr) shadow[int'(a)] = d;
    endtask

    localparam int NV = 10;
    // {write flag, address, data}
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 17'h00000, 8'hA5},
        {1'b1, 17'h1FFFF, 8'h3C},
        {1'b0, 17'h00000, 8'h00},
        {1'b0, 17'h1FFFF, 8'h00},
        {1'b1, 17'h0ABCD, 8'hFF},
        {1'b1, 17'h0ABCD, 8'h5A},
        {1'b0, 17'h0ABCD, 8'h00},
        {1'b1, 17'h10000, 8'h01},
        {1'b0, 17'h10000, 8'h00},
        {1'b0, 17'h04242, 8'h00}
    };

    int lat;
    int dn0;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 controls high", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b111);
        chk(!mem_dout_en && !rsp_done, "R1 drive/done low", {mem_dout_en, rsp_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && !mem_dout_en, "R1 first cycle idle", {mem_ce_n, mem_dout_en}, 2'b10);
        mon_on = 1'b1;

        for (int i = 0; i < NV; i++) begin
            dn0 = n_done;
            do_req(VEC[i][25], VEC[i][24:8], VEC[i][7:0], lat);
            chk(lat == 7, "R4 done latency", lat, 7);
            if (VEC[i][25]) begin
                chk(peek(int'(VEC[i][24:8])) == VEC[i][7:0], "R3 stored byte", peek(int'(VEC[i][24:8])), VEC[i][7:0]);
            end else begin
                chk(rsp_rdata == expect_at(int'(VEC[i][24:8])), "R2 R9 read data", rsp_rdata, expect_at(int'(VEC[i][24:8])));
            end
            @(negedge clk);
            chk(n_done == dn0 + 1 && !rsp_done, "R4 single pulse", n_done - dn0, 1);
            chk(mem_ce_n, "R8 standby when idle", int'(mem_ce_n), 1);
        end

        // R9: extreme addresses seen on the pins during a read
        req = 1'b1; req_wr = 1'b0; req_addr = 17'h1FFFF;
        @(negedge clk); req = 1'b0;
        chk(mem_addr == 17'h1FFFF && !mem_oe_n, "R9 max address on pins", int'(mem_addr), 17'h1FFFF);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);

        // R5: a write request during a busy read must be ignored
        shadow[17'h00777] = 8'h11;
        do_req(1'b1, 17'h00777, 8'h11, lat);
        @(negedge clk);
        dn0 = n_done;
        req = 1'b1; req_wr = 1'b0; req_addr = 17'h00000;
        @(negedge clk); req = 1'b0;
        @(negedge clk);
        req = 1'b1; req_wr = 1'b1; req_addr = 17'h00777; req_wdata = 8'h99;
        @(negedge clk); req = 1'b0;
        repeat (12) @(negedge clk);
        chk(n_done == dn0 + 1, "R5 no extra done", n_done - dn0, 1);
        chk(peek(17'h00777) == 8'h11, "R5 memory untouched", peek(17'h00777), 8'h11);
        chk(rsp_rdata == 8'hA5, "R2 read during ignored req", rsp_rdata, 8'hA5);

        // R7: write right at the done of a read (turnaround path)
        req = 1'b1; req_wr = 1'b0; req_addr = 17'h00777;
        @(negedge clk); req = 1'b0;
        while (!rsp_done) @(negedge clk);
        chk(rsp_rdata == 8'h11, "R2 readback", rsp_rdata, 8'h11);
        do_req(1'b1, 17'h00778, 8'hC3, lat);
        chk(lat == 7, "R4 R7 write after read latency", lat, 7);
        chk(peek(17'h00778) == 8'hC3, "R3 write after read", peek(17'h00778), 8'hC3);

        // R1: reset during a write pulse returns controls to idle
        req = 1'b1; req_wr = 1'b1; req_addr = 17'h00100; req_wdata = 8'h77;
        @(negedge clk); req = 1'b0;
        repeat (2) @(negedge clk);
        mon_on = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(mem_we_n && mem_ce_n && !mem_dout_en && !rsp_done, "R1 reset mid-write",
            {mem_we_n, mem_ce_n, mem_dout_en, rsp_done}, 4'b1100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=0x1 expected=0x0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule